// File: doc/BRIEF.md
# OLED serial command and data decoder

This block sits behind a two-wire bus slave front end and interprets the byte stream written to a small monochrome OLED panel controller. Each received byte arrives as a one-cycle strobe with its data; a separate strobe marks the end of a bus transfer. The decoder tracks a three-state mode (idle, command, data). In idle, a control prefix byte selects whether the bytes that follow are commands or display data. Command bytes move the write pointer, set the display flags, or are accepted and ignored. Some commands take one argument byte, which the decoder consumes and throws away.

Data bytes are written into a page-organised frame memory of 8 pages by 132 columns through a single write port, and each write raises a redraw flag. A downstream pixel scanner reads that flag and acknowledges it. The page, column, start line and flags (enable, inverse, entire-display-on, mirror) are driven out so the scanner can use them. A read request from the bus side always returns 0xFF.

Top module: `oled_cmd_decoder`

## Requirements
- R1: In idle, byte 0x80 switches the mode to command and byte 0x40 switches it to data. Neither prefix writes memory or raises err_o.
- R2: In idle, any byte other than 0x80 or 0x40 raises err_o in the cycle of its strobe and leaves the mode idle.
- R3: In data mode, a byte with column < 132 drives mem_we_o high in the same cycle, with mem_addr_o = column + page*132 and mem_wdata_o = the byte. The column then increments. A byte at column >= 132 is dropped without a write. Data mode persists across bytes.
- R4: redraw_o goes high the cycle after an accepted data write and stays high until redraw_ack_i is sampled high. If a write and an ack occur in the same cycle, the write wins.
- R5: After a command byte is decoded (not skipped), the mode returns to idle, so a data or command byte that follows needs a new prefix.
- R6: Command 0x00–0x0F sets column[3:0] to byte[3:0]. Command 0x10–0x20 sets column[7:4] to byte[3:0]. The other column nibble is kept in both cases.
- R7: Command 0xB0–0xBF sets the page to byte[2:0]. Command 0x40–0x7F sets the start line to 0.
- R8: The flag commands write byte[0] to their flag: 0xA0/0xA1 to mirror, 0xA4/0xA5 to entire-display-on, 0xA6/0xA7 to inverse, 0xAE/0xAF to display enable.
- R9: Commands 0x81, 0xA8, 0xAD, 0xD3, 0xD5, 0xD8, 0xD9, 0xDA and 0xDB arm a skip. The next byte that arrives in command mode is discarded with no effect on pointer or flags, the skip clears, and the mode stays command.
- R10: Commands 0xE3 and 0xC0–0xC8 have no effect. Any command value that no other rule covers raises err_o in its cycle, and the mode still returns to idle.
- R11: A transfer-finished strobe forces the mode to idle on the next edge. A byte in the same cycle is processed first. The skip state is unaffected.
- R12: rd_data_o is 0xFF while rd_req_i is high and 0x00 otherwise.
- R13: After reset, page, column, start line, all flags and redraw_o are 0 and the mode is idle with no skip armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| byte_valid_i | input | 1 | One-cycle strobe for a received byte |
| byte_i | input | 8 | Received byte |
| xfer_done_i | input | 1 | Bus transfer finished |
| rd_req_i | input | 1 | Bus read request |
| rd_data_o | output | 8 | Read reply byte |
| redraw_ack_i | input | 1 | Scanner acknowledges redraw |
| mem_we_o | output | 1 | Frame memory write enable |
| mem_addr_o | output | 11 | Frame memory byte address |
| mem_wdata_o | output | 8 | Frame memory write data |
| redraw_o | output | 1 | Frame contents changed |
| err_o | output | 1 | Unexpected prefix or unknown command |
| page_o | output | 3 | Current page |
| col_o | output | 8 | Current column |
| start_line_o | output | 6 | Display start line |
| disp_en_o | output | 1 | Display enable |
| inverse_o | output | 1 | Inverse video |
| all_on_o | output | 1 | Entire display forced on |
| mirror_o | output | 1 | Horizontal mirror |

## Verification
The assertions assume that byte_valid_i is a single-cycle strobe carrying at most one byte per clock. They also assume that xfer_done_i may coincide with a byte, and that the byte is then processed before the mode falls back to idle. The stimulus keeps to that contract: directed sequences walk through every command group, the skip-then-command chain and column overflow, and a long pseudo-random stream mixes prefixes, arbitrary bytes, finished events and acks. A behavioural model checks every output on every clock.

// File: rtl/oled_dec_pkg.sv
package oled_dec_pkg;
  typedef enum logic [1:0] {MD_IDLE, MD_DATA, MD_CMD} mode_e;

  typedef enum logic [3:0] {
    CC_NOP, CC_COL_LO, CC_COL_HI, CC_START, CC_SKIP,
    CC_MIRROR, CC_ALLON, CC_INV, CC_EN, CC_PAGE, CC_BAD
  } cmd_e;

  localparam logic [7:0] PFX_CMD  = 8'h80;
  localparam logic [7:0] PFX_DATA = 8'h40;
endpackage

// File: rtl/oled_cmd_class.sv
module oled_cmd_class
  import oled_dec_pkg::*;
(
  input  logic [7:0] byte_i,
  output cmd_e       cls_o
);
  always_comb begin
    cls_o = CC_BAD;
    if (byte_i <= 8'h0f)                            cls_o = CC_COL_LO;
    else if (byte_i <= 8'h20)                       cls_o = CC_COL_HI;
    else if (byte_i >= 8'h40 && byte_i <= 8'h7f)    cls_o = CC_START;
    else if (byte_i >= 8'hb0 && byte_i <= 8'hbf)    cls_o = CC_PAGE;
    else if (byte_i >= 8'hc0 && byte_i <= 8'hc8)    cls_o = CC_NOP;
    else begin
      case (byte_i)
        8'ha0, 8'ha1: cls_o = CC_MIRROR;
        8'ha4, 8'ha5: cls_o = CC_ALLON;
        8'ha6, 8'ha7: cls_o = CC_INV;
        8'hae, 8'haf: cls_o = CC_EN;
        8'h81, 8'ha8, 8'had, 8'hd3, 8'hd5,
        8'hd8, 8'hd9, 8'hda, 8'hdb: cls_o = CC_SKIP;
        8'he3:        cls_o = CC_NOP;
        default:      cls_o = CC_BAD;
      endcase
    end
  end
endmodule

// File: rtl/oled_wr_addr.sv
module oled_wr_addr #(
  parameter int COLS   = 132,
  parameter int COL_W  = 8,
  parameter int PAGE_W = 3,
  parameter int ADDR_W = 11
) (
  input  logic [COL_W-1:0]  col_i,
  input  logic [PAGE_W-1:0] page_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam logic [ADDR_W-1:0] STRIDE = ADDR_W'(COLS);
  always_comb addr_o = ADDR_W'(col_i) + ADDR_W'(page_i) * STRIDE;
endmodule

// File: rtl/oled_cmd_decoder.sv
module oled_cmd_decoder
  import oled_dec_pkg::*;
#(
  parameter int COLS   = 132,
  parameter int PAGES  = 8,
  parameter int LINE_W = 6,
  localparam int COL_W  = 8,
  localparam int PAGE_W = $clog2(PAGES),
  localparam int ADDR_W = $clog2(COLS * PAGES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              byte_valid_i,
  input  logic [7:0]        byte_i,
  input  logic              xfer_done_i,
  input  logic              rd_req_i,
  output logic [7:0]        rd_data_o,
  input  logic              redraw_ack_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_wdata_o,
  output logic              redraw_o,
  output logic              err_o,
  output logic [PAGE_W-1:0] page_o,
  output logic [COL_W-1:0]  col_o,
  output logic [LINE_W-1:0] start_line_o,
  output logic              disp_en_o,
  output logic              inverse_o,
  output logic              all_on_o,
  output logic              mirror_o
);
  localparam logic [COL_W-1:0] COL_LIM = COL_W'(COLS);

  mode_e               mode_q;
  logic                skip_q;
  logic [PAGE_W-1:0]   page_q;
  logic [COL_W-1:0]    col_q;
  logic [LINE_W-1:0]   start_q;
  logic                en_q, inv_q, allon_q, mirror_q, redraw_q;
  cmd_e                cls;
  logic                wr_ok, cmd_live, pfx_bad;

  oled_cmd_class u_class (.byte_i(byte_i), .cls_o(cls));

  oled_wr_addr #(.COLS(COLS), .COL_W(COL_W), .PAGE_W(PAGE_W), .ADDR_W(ADDR_W))
    u_addr (.col_i(col_q), .page_i(page_q), .addr_o(mem_addr_o));

  always_comb begin
    wr_ok    = byte_valid_i && mode_q == MD_DATA && col_q < COL_LIM;
    cmd_live = byte_valid_i && mode_q == MD_CMD && !skip_q;
    pfx_bad  = byte_valid_i && mode_q == MD_IDLE &&
               byte_i != PFX_CMD && byte_i != PFX_DATA;
  end

  assign mem_we_o     = wr_ok;
  assign mem_wdata_o  = byte_i;
  assign err_o        = pfx_bad || (cmd_live && cls == CC_BAD);
  assign rd_data_o    = rd_req_i ? 8'hff : 8'h00;
  assign redraw_o     = redraw_q;
  assign page_o       = page_q;
  assign col_o        = col_q;
  assign start_line_o = start_q;
  assign disp_en_o    = en_q;
  assign inverse_o    = inv_q;
  assign all_on_o     = allon_q;
  assign mirror_o     = mirror_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= MD_IDLE;
      skip_q   <= 1'b0;
      page_q   <= '0;
      col_q    <= '0;
      start_q  <= '0;
      en_q     <= 1'b0;
      inv_q    <= 1'b0;
      allon_q  <= 1'b0;
      mirror_q <= 1'b0;
      redraw_q <= 1'b0;
    end else begin
      if (redraw_ack_i) redraw_q <= 1'b0;
      if (wr_ok)        redraw_q <= 1'b1;
      if (byte_valid_i) begin
        unique case (mode_q)
          MD_IDLE: begin
            if (byte_i == PFX_CMD)       mode_q <= MD_CMD;
            else if (byte_i == PFX_DATA) mode_q <= MD_DATA;
          end
          MD_DATA: if (wr_ok) col_q <= col_q + 1'b1;
          MD_CMD: begin
            if (skip_q) skip_q <= 1'b0;  // argument byte dropped, mode kept
            else begin
              mode_q <= MD_IDLE;
              case (cls)
                CC_COL_LO: col_q[3:0]  <= byte_i[3:0];
                CC_COL_HI: col_q[7:4]  <= byte_i[3:0];
                CC_START:  start_q     <= '0;
                CC_PAGE:   page_q      <= byte_i[PAGE_W-1:0];
                CC_MIRROR: mirror_q    <= byte_i[0];
                CC_ALLON:  allon_q     <= byte_i[0];
                CC_INV:    inv_q       <= byte_i[0];
                CC_EN:     en_q        <= byte_i[0];
                CC_SKIP:   skip_q      <= 1'b1;
                default:   ;
              endcase
            end
          end
          default: mode_q <= MD_IDLE;
        endcase
      end
      if (xfer_done_i) mode_q <= MD_IDLE;
    end
  end

  assert_col_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> col_q == $past(col_q) + 8'd1);
  assert_we_data_mode_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> mode_q == MD_DATA);
  assert_redraw_set_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> redraw_o);
  assert_done_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_done_i |=> mode_q == MD_IDLE);
  assert_err_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> mode_q == MD_IDLE);
  assert_skip_drop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_valid_i && skip_q && mode_q == MD_CMD) |=>
      (!skip_q && $stable(col_o) && $stable(page_o) && $stable(inverse_o) && $stable(disp_en_o)));
endmodule

// File: tb/oled_cmd_decoder_test.sv
module oled_cmd_decoder_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bv = 1'b0, done = 1'b0, rd = 1'b0, ack = 1'b0;
  logic [7:0] bd = 8'h00;
  logic [7:0] rdd, wdata;
  logic we, red, err, en, inv, allon, mir;
  logic [10:0] addr;
  logic [2:0] page;
  logic [7:0] col;
  logic [5:0] sl;

  int total = 0, bad = 0;
  int m_mode = 0, m_skip = 0, m_page = 0, m_col = 0, m_start = 0;
  int m_en = 0, m_inv = 0, m_all = 0, m_mir = 0, m_red = 0;

  always #5 clk = ~clk;

  oled_cmd_decoder uut (
    .clk_i(clk), .rst_ni(rst_n), .byte_valid_i(bv), .byte_i(bd),
    .xfer_done_i(done), .rd_req_i(rd), .rd_data_o(rdd), .redraw_ack_i(ack),
    .mem_we_o(we), .mem_addr_o(addr), .mem_wdata_o(wdata), .redraw_o(red),
    .err_o(err), .page_o(page), .col_o(col), .start_line_o(sl),
    .disp_en_o(en), .inverse_o(inv), .all_on_o(allon), .mirror_o(mir));

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic bit is_skip(input int d);
    return d == 'h81 || d == 'ha8 || d == 'had || d == 'hd3 || d == 'hd5 ||
           d == 'hd8 || d == 'hd9 || d == 'hda || d == 'hdb;
  endfunction

  function automatic bit is_known(input int d);
    if (d <= 'h20 || (d >= 'h40 && d <= 'h7f)) return 1;
    if ((d >= 'hb0 && d <= 'hbf) || (d >= 'hc0 && d <= 'hc8) || d == 'he3) return 1;
    if (d == 'ha0 || d == 'ha1 || d == 'ha4 || d == 'ha5 || d == 'ha6 ||
        d == 'ha7 || d == 'hae || d == 'haf) return 1;
    return is_skip(d);
  endfunction

  task automatic cyc(input bit v, input int d, input bit dn, input bit r, input bit a);
    bit ewe, eerr;
    bv = v; bd = d[7:0]; done = dn; rd = r; ack = a;
    #3;
    ewe  = v && m_mode == 1 && m_col < 132;
    eerr = v && ((m_mode == 0 && d != 'h80 && d != 'h40) ||
                 (m_mode == 2 && m_skip == 0 && !is_known(d)));
    chk("R3 we", we, ewe);
    if (ewe) begin
      chk("R3 addr", addr, m_col + m_page * 132);
      chk("R3 wdata", wdata, d);
    end
    chk("R2/R10 err", err, eerr);
    chk("R12 rd", rdd, r ? 'hff : 0);
    chk("R4 redraw", red, m_red);
    chk("R6 col", col, m_col);
    chk("R7 page", page, m_page);
    chk("R7 start", sl, m_start);
    chk("R8 en", en, m_en);
    chk("R8 inv", inv, m_inv);
    chk("R8 allon", allon, m_all);
    chk("R8 mirror", mir, m_mir);
    @(posedge clk);
    if (a) m_red = 0;
    if (ewe) m_red = 1;
    if (v) begin
      case (m_mode)
        0: if (d == 'h80) m_mode = 2; else if (d == 'h40) m_mode = 1;
        1: if (m_col < 132) m_col++;
        default: begin
          if (m_skip) m_skip = 0;
          else begin
            m_mode = 0;
            if (d <= 'h0f) m_col = (m_col & 'hf0) | (d & 'hf);
            else if (d <= 'h20) m_col = (m_col & 'h0f) | ((d & 'hf) << 4);
            else if (d >= 'h40 && d <= 'h7f) m_start = 0;
            else if (d >= 'hb0 && d <= 'hbf) m_page = d & 7;
            else if (d == 'ha0 || d == 'ha1) m_mir = d & 1;
            else if (d == 'ha4 || d == 'ha5) m_all = d & 1;
            else if (d == 'ha6 || d == 'ha7) m_inv = d & 1;
            else if (d == 'hae || d == 'haf) m_en = d & 1;
            else if (is_skip(d)) m_skip = 1;
          end
        end
      endcase
    end
    if (dn) m_mode = 0;
    #1;
  endtask

  task automatic b(input int d);
    cyc(1, d, 0, 0, 0);
  endtask

  task automatic cmd(input int d);
    b('h80); b(d);
  endtask

  initial begin
    #2_000_000;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int lf;
    #7;
    // R13 reset state
    chk("R13 col", col, 0); chk("R13 page", page, 0); chk("R13 redraw", red, 0);
    chk("R13 flags", {en, inv, allon, mir}, 0); chk("R13 start", sl, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    @(posedge clk); #1;
    cyc(0, 0, 0, 0, 0);
    // R8 flags
    cmd('haf); cmd('ha7); cmd('ha5); cmd('ha1);
    cmd('ha6); cmd('ha4);
    // R7 page, R6 column nibbles
    cmd('hb3); cmd('h05); cmd('h17);
    // R3 data with overflow at column 132, R4 redraw
    b('h40);
    for (int i = 0; i < 20; i++) b('h10 + i);
    cyc(0, 0, 0, 0, 1);
    cyc(0, 0, 1, 0, 0);              // R11 finish
    b('h55);                         // R2 idle garbage
    // R9 skip: argument dropped, mode stays command
    cmd('h81); b('h80); b('hb7); b('ha7);
    b('h40);                         // R5 back to idle: prefix accepted
    b('h99);
    cyc(0, 0, 1, 0, 0);
    // R10 unknown and nops
    cmd('hff); cmd('he3); cmd('hc5); cmd('hc9);
    cmd('h45); cmd('h20); cmd('h0a); // R7 start, R6 high nibble zero
    cyc(0, 0, 0, 1, 0);              // R12
    // R1 data prefix, R11 byte and finish together
    b('h40); cyc(1, 'h3c, 1, 0, 1); b('h3c);
    // R5 command after command needs prefix
    cmd('hae); b('had);
    // R4 ack and write same cycle
    b('h40); cyc(1, 'h11, 0, 0, 1); cyc(0, 0, 0, 0, 1);
    cyc(0, 0, 1, 0, 0);
    lf = 'hace1;
    for (int i = 0; i < 600; i++) begin
      int d;
      lf = ((lf << 1) | (((lf >> 15) ^ (lf >> 13) ^ (lf >> 12) ^ (lf >> 10)) & 1)) & 'hffff;
      d = (lf[3:0] == 0) ? 'h80 : (lf[3:0] == 1) ? 'h40 : ((lf >> 8) & 'hff);
      cyc(lf[6:4] != 0, d, lf[11:9] == 0, lf[12], lf[14:13] == 0);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule